// File: doc/BRIEF.md
# Mode-Banked Three-Port Register File

This block is the register storage of a small 32-bit processor core. Software sees sixteen register names. Physically the block holds twenty-five words, because three exception modes each get private copies of some registers. Each access port carries a 4-bit register name and the current processor mode. A per-port decoder turns that pair into a one-hot select of one physical word. Two words can be read and one written in every cycle.

Name 15 is the program counter. Addresses are 26 bits wide and always word aligned, so only address bits 25 down to 2 are kept. The unused bits read as zero. The counter can be loaded by an ordinary write, or advanced by one word through a dedicated step input. Instruction decode, the ALU and the logic that changes modes are outside the block.

Top module: `bank_regfile`

## Requirements
- R1: The block stores 25 physical words of 32 bits. A write is stored at the rising clock edge. Both read ports return the addressed word combinationally, with no clock.
- R2: Read port A, read port B and the write port act independently in the same cycle. When `wrEn` is low, no stored word changes, whatever `wrAddr` and `wrData` carry.
- R3: Each of the three ports decodes its own (register name, mode) pair to exactly one physical word.
- R4: The mode code is 00 user, 01 fast interrupt, 10 interrupt, 11 supervisor. Fast-interrupt mode uses private copies of names 10 to 14. Interrupt mode and supervisor mode each use private copies of names 13 and 14. Every other name in every mode uses the user copy.
- R5: Name 15 is the program counter, and one copy is shared by all modes. Its bits 31:26 and 1:0 always read as 0. Writes to those bits are dropped, and a write stores `wrData[25:2]`.
- R6: If a read port addresses the word being written in the same cycle, it returns the old value until the edge. After the edge it returns the new value.
- R7: When `pcInc` is high and no write to name 15 happens in that cycle, the program counter advances by 4. It wraps from 0x03FFFFFC to 0. A write to name 15 in the same cycle takes priority over the step.
- R8: While `rstN` is low the program counter reads 0. The other words are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the program counter |
| mode | input | 2 | Current processor mode (00 user, 01 fast interrupt, 10 interrupt, 11 supervisor) |
| rdAddrA | input | 4 | Register name for read port A |
| rdDataA | output | 32 | Read data of port A |
| rdAddrB | input | 4 | Register name for read port B |
| rdDataB | output | 32 | Read data of port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 4 | Register name for the write port |
| wrData | input | 32 | Write data |
| pcInc | input | 1 | Advance the program counter by one word |

## Verification
Every name is written in all four modes, each with a value that encodes both the mode and the name. All sixteen names are then read back in every mode on both ports, with port B walking in the opposite direction to port A. A copy that is wrongly shared or wrongly private then shows up as a value carrying the wrong mode. A same-cycle read of the word under write tells read-before-write apart from write-through. A cycle with the write disabled but with live address and data shows whether any word is still touched. The program counter is loaded with a sweep of patterns that have the dropped bits set, stepped across its wrap point, and given a load and a step in the same cycle. Together these separate truncation, increment and priority faults.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

  typedef enum logic [1:0] {
    MODE_USR = 2'b00,
    MODE_FIQ = 2'b01,
    MODE_IRQ = 2'b10,
    MODE_SVC = 2'b11
  } cpu_mode_e;

  localparam int ARCH_W     = 4;
  localparam int PHYS_CNT   = 25;
  localparam int PHYS_IDX_W = $clog2(PHYS_CNT);
  localparam int PC_PHYS    = 15;

  localparam logic [ARCH_W-1:0]     PC_ARCH  = 4'd15;
  localparam logic [PHYS_IDX_W-1:0] FIQ_BASE = 5'd16;
  localparam logic [PHYS_IDX_W-1:0] IRQ_BASE = 5'd21;
  localparam logic [PHYS_IDX_W-1:0] SVC_BASE = 5'd23;

  // Strobes from the control side to the storage side
  typedef struct packed {
    logic [PHYS_CNT-1:0] wrSel;
    logic                pcStep;
  } rf_strobe_t;

  // Map a (register name, mode) pair to a physical word index
  function automatic logic [PHYS_IDX_W-1:0] physIndex(
    input logic [ARCH_W-1:0] arch,
    input cpu_mode_e         mode
  );
    logic [PHYS_IDX_W-1:0] idx;
    idx = PHYS_IDX_W'(arch);
    case (mode)
      MODE_FIQ: if (arch >= 4'd10 && arch <= 4'd14)
                  idx = FIQ_BASE + PHYS_IDX_W'(arch - 4'd10);
      MODE_IRQ: if (arch == 4'd13 || arch == 4'd14)
                  idx = IRQ_BASE + PHYS_IDX_W'(arch - 4'd13);
      MODE_SVC: if (arch == 4'd13 || arch == 4'd14)
                  idx = SVC_BASE + PHYS_IDX_W'(arch - 4'd13);
      default:  idx = PHYS_IDX_W'(arch);
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/regfile_decoder.sv
module regfile_decoder
  import bank_regfile_pkg::*;
(
  input  logic [ARCH_W-1:0]   archIdx,
  input  cpu_mode_e           mode,
  input  logic                enable,
  output logic [PHYS_CNT-1:0] sel
);

  logic [PHYS_IDX_W-1:0] physIdx;

  always_comb begin
    physIdx = physIndex(archIdx, mode);
    sel     = '0;
    if (enable) sel[physIdx] = 1'b1;
  end

endmodule

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import bank_regfile_pkg::*;
(
  input  cpu_mode_e           mode,
  input  logic [ARCH_W-1:0]   rdAddrA,
  input  logic [ARCH_W-1:0]   rdAddrB,
  input  logic                wrEn,
  input  logic [ARCH_W-1:0]   wrAddr,
  input  logic                pcInc,
  output logic [PHYS_CNT-1:0] rdSelA,
  output logic [PHYS_CNT-1:0] rdSelB,
  output rf_strobe_t          strb
);

  localparam int PORT_CNT = 3;

  logic [ARCH_W-1:0]   portAddr [PORT_CNT];
  logic                portEn   [PORT_CNT];
  logic [PHYS_CNT-1:0] portSel  [PORT_CNT];

  assign portAddr[0] = rdAddrA;
  assign portAddr[1] = rdAddrB;
  assign portAddr[2] = wrAddr;
  assign portEn[0]   = 1'b1;
  assign portEn[1]   = 1'b1;
  assign portEn[2]   = wrEn;

  for (genvar p = 0; p < PORT_CNT; p++) begin : g_dec
    regfile_decoder dec_i (
      .archIdx (portAddr[p]),
      .mode    (mode),
      .enable  (portEn[p]),
      .sel     (portSel[p])
    );
  end

  assign rdSelA      = portSel[0];
  assign rdSelB      = portSel[1];
  assign strb.wrSel  = portSel[2];
  assign strb.pcStep = pcInc && !(wrEn && wrAddr == PC_ARCH);

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  rf_strobe_t          strb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [PHYS_CNT-1:0] rdSelA,
  input  logic [PHYS_CNT-1:0] rdSelB,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB
);

  localparam int PC_W = PC_HI - PC_LO + 1;

  logic [DATA_W-1:0] regView [PHYS_CNT];

  for (genvar i = 0; i < PHYS_CNT; i++) begin : g_word
    if (i == PC_PHYS) begin : g_pc
      // Only the meaningful address bits are stored
      logic [PC_W-1:0] pcQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               pcQ <= '0;
        else if (strb.wrSel[i])  pcQ <= wrData[PC_HI:PC_LO];
        else if (strb.pcStep)    pcQ <= pcQ + 1'b1;
      end
      assign regView[i] = DATA_W'({pcQ, {PC_LO{1'b0}}});
    end else begin : g_gpr
      logic [DATA_W-1:0] wordQ;
      always_ff @(posedge clk) begin
        if (strb.wrSel[i]) wordQ <= wrData;
      end
      assign regView[i] = wordQ;
    end
  end

  // AND-OR multiplexers driven by one-hot selects
  always_comb begin
    rdDataA = '0;
    rdDataB = '0;
    for (int i = 0; i < PHYS_CNT; i++) begin
      rdDataA = rdDataA | (regView[i] & {DATA_W{rdSelA[i]}});
      rdDataB = rdDataB | (regView[i] & {DATA_W{rdSelB[i]}});
    end
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        mode,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcInc
);

  rf_strobe_t          ctrlStrb;
  logic [PHYS_CNT-1:0] rdSelA;
  logic [PHYS_CNT-1:0] rdSelB;

  regfile_ctrl ctrl_i (
    .mode    (cpu_mode_e'(mode)),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .pcInc   (pcInc),
    .rdSelA  (rdSelA),
    .rdSelB  (rdSelB),
    .strb    (ctrlStrb)
  );

  regfile_dp #(.DATA_W(DATA_W), .PC_HI(PC_HI), .PC_LO(PC_LO)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (ctrlStrb),
    .wrData  (wrData),
    .rdSelA  (rdSelA),
    .rdSelB  (rdSelB),
    .rdDataA (rdDataA),
    .rdDataB (rdDataB)
  );

endmodule

// File: rtl/bank_regfile_checker.sv
module bank_regfile_checker
  import bank_regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_HI  = 25,
  parameter int PC_LO  = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic [3:0]          rdAddrA,
  input logic [DATA_W-1:0]   rdDataA,
  input logic                wrEn,
  input logic [3:0]          wrAddr,
  input logic [DATA_W-1:0]   wrData,
  input logic                pcInc,
  input logic [PHYS_CNT-1:0] rdSelA,
  input logic [PHYS_CNT-1:0] rdSelB,
  input rf_strobe_t          ctrlStrb
);

  // Set once a full clock has passed out of reset
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r3_sel_a_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdSelA));

  a_r3_sel_b_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdSelB));

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> ctrlStrb.wrSel == '0);

  a_r5_pc_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    rdAddrA == 4'd15 |-> (rdDataA[DATA_W-1:PC_HI+1] == '0 && rdDataA[PC_LO-1:0] == '0));

  a_r5_pc_load: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wrEn && wrAddr == 4'd15) && rdAddrA == 4'd15)
      |-> rdDataA[PC_HI:PC_LO] == $past(wrData[PC_HI:PC_LO]));

  a_r7_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(pcInc && !(wrEn && wrAddr == 4'd15)) &&
     $past(rdAddrA) == 4'd15 && rdAddrA == 4'd15)
      |-> rdDataA[PC_HI:PC_LO] == $past(rdDataA[PC_HI:PC_LO]) + 1'b1);

endmodule

bind bank_regfile bank_regfile_checker #(.DATA_W(DATA_W), .PC_HI(PC_HI), .PC_LO(PC_LO)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rdAddrA  (rdAddrA),
  .rdDataA  (rdDataA),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .pcInc    (pcInc),
  .rdSelA   (rdSelA),
  .rdSelB   (rdSelB),
  .ctrlStrb (ctrlStrb)
);

// File: tb/bank_regfile_tb_top.sv
`timescale 1ns/1ps
module bank_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  mode;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        wrEn, pcInc;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [31:0] mdl [25];
  logic [23:0] pcModel;

  always #2.5 clk = ~clk;

  bank_regfile dut_i (
    .clk(clk), .rstN(rstN), .mode(mode),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pcInc(pcInc)
  );

  // Expected physical slot per the banking requirement R4
  function automatic int slotOf(int a, int m);
    if (m == 1 && a >= 10 && a <= 14) return 16 + a - 10;
    if (m == 2 && a >= 13 && a <= 14) return 21 + a - 13;
    if (m == 3 && a >= 13 && a <= 14) return 23 + a - 13;
    return a;
  endfunction

  function automatic logic [31:0] expRead(int a, int m);
    if (a == 15) return {6'b0, pcModel, 2'b0};
    return mdl[slotOf(a, m)];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doWrite(int m, int a, logic [31:0] d);
    mode = 2'(m); wrAddr = 4'(a); wrData = d; wrEn = 1'b1;
    @(posedge clk);
    if (a == 15) pcModel = d[25:2];
    else mdl[slotOf(a, m)] = d;
    #1 wrEn = 1'b0;
  endtask

  task automatic readAll(int m, string tag);
    mode = 2'(m);
    for (int a = 0; a < 16; a++) begin
      rdAddrA = 4'(a); rdAddrB = 4'(15 - a);
      #0.2;
      check(tag, rdDataA, expRead(a, m));
      check(tag, rdDataB, expRead(15 - a, m));
    end
  endtask

  task automatic stepPc(int n);
    pcInc = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      pcModel = pcModel + 1'b1;
    end
    #1 pcInc = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    rstN = 1'b0; mode = 2'b00; rdAddrA = 4'd15; rdAddrB = 4'd15;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; pcInc = 1'b0;
    for (int i = 0; i < 25; i++) mdl[i] = 'x;
    pcModel = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: program counter is zero during reset in every mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); #0.2;
      check("R8 pc in reset", rdDataA, 32'h0);
    end
    rstN = 1'b1;
    @(posedge clk); #1;

    // Fill every name in every mode with a mode/name tagged pattern
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 15; a++)
        doWrite(m, a, (32'h1000_0000 * (m + 1)) ^ (32'h0101_0101 * a) ^ 32'h0000_5A00);
    // R1/R3/R4: both ports, all names, all modes
    for (int m = 0; m < 4; m++) readAll(m, "R1/R3/R4 banked readback");

    // R6: same-cycle read of the word under write returns the old value
    mode = 2'b00; rdAddrA = 4'd3; rdAddrB = 4'd4;
    wrAddr = 4'd3; wrData = 32'hDEAD_BEEF; wrEn = 1'b1;
    #0.2;
    check("R6 old value during write", rdDataA, mdl[3]);
    @(posedge clk);
    mdl[3] = 32'hDEAD_BEEF;
    #1 wrEn = 1'b0;
    check("R6 new value after edge", rdDataA, 32'hDEAD_BEEF);
    check("R2 port B unaffected", rdDataB, mdl[4]);

    // R2: disabled write with live address and data changes nothing
    mode = 2'b01; wrAddr = 4'd12; wrData = 32'hFFFF_0000; wrEn = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    readAll(1, "R2 idle write");

    // R5: pc truncation, shared across modes
    for (int k = 0; k < 16; k++) begin
      doWrite(k % 4, 15, 32'h8000_0003 + 32'h0111_1113 * k);
      for (int m = 0; m < 4; m++) begin
        mode = 2'(m); rdAddrB = 4'd15; #0.2;
        check("R5 pc truncated/shared", rdDataB, expRead(15, m));
      end
    end

    // R7: step with wrap
    doWrite(0, 15, 32'hFFFF_FFFF);
    rdAddrA = 4'd15; #0.2;
    check("R5 pc all-ones write", rdDataA, 32'h03FF_FFFC);
    stepPc(1);
    check("R7 pc wrap", rdDataA, 32'h0);
    stepPc(5);
    check("R7 pc five steps", rdDataA, 32'h0000_0014);
    // R7: write wins over step
    pcInc = 1'b1;
    doWrite(2, 15, 32'h0000_123B);
    pcInc = 1'b0; #0.2;
    check("R7 write priority", rdDataA, 32'h0000_1238);
    // R7: step alongside a write to another name
    pcInc = 1'b1;
    doWrite(0, 7, 32'h7777_7777);
    pcModel = pcModel + 1'b1;
    pcInc = 1'b0; #0.2;
    check("R7 step with other write", rdDataA, 32'h0000_123C);
    readAll(0, "R2 final readback");

    finish();
  end

endmodule